// File: doc/BRIEF.md
# Standby Wake-up Clock Controller

This block governs the deepest clock-off state of a small microcontroller core. When the CPU signals a sleep request while the standby-enable input is high, the block parks the core in software standby. The oscillator enable and every clock enable drop low, and the block waits for an external pin to wake it. Three pins can end that state, and they are all brought into the clock domain through a shared two-stage synchroniser: the non-maskable interrupt pin, the active-low reset pin and the active-low hardware-standby pin.

An interrupt-pin wake does not release the chip clock at once. The oscillator restarts, but only an 8-bit settling counter receives clock pulses. A prescaler divides the counter's rate, and a 3-bit select code picks the ratio. Only when the counter wraps from 255 to 0 does the chip clock come back, and a one-cycle request tells the interrupt logic to start the handler. A reset-pin wake bypasses the settling count. The oscillator runs while the pin is held low, and all clocks return together when it rises. A low hardware-standby pin sends the block straight to hardware standby. A programmable polarity bit decides whether a falling or a rising interrupt edge counts.

Top module: `standby_wake_ctrl`

## Requirements
- R1: After block reset the state is run: `status_o` = 0, `clk_en_o` = 1, `osc_en_o` = 1, and the edge-select bit is 0, so a falling interrupt edge is the active one.
- R2: A sleep request with `stby_en_i` = 1 in run moves the block to software standby (`status_o` = 1) with `clk_en_o`, `osc_en_o` and `cnt_clk_en_o` all 0. With `stby_en_i` = 0 a sleep request leaves the block in run.
- R3: In software standby, an interrupt-pin edge of the selected polarity starts settling (`status_o` = 2). Settling sets `osc_en_o` = 1 and `cnt_clk_en_o` = 1 and keeps `clk_en_o` = 0. An edge of the other polarity leaves the block in standby.
- R4: Settling lasts exactly 256 × D clock cycles. D is the prescaler ratio for select codes 0..7: 2, 8, 32, 64, 128, 256, 1024 and 4096. The code is captured on the cycle settling starts.
- R5: When the settling counter wraps, the block returns to run with `clk_en_o` = 1, and `nmi_req_o` is high for exactly one cycle.
- R6: Interrupt-pin edges during settling neither restart the count nor raise an extra `nmi_req_o`.
- R7: In standby or settling, a low reset pin moves the block to reset-hold. Reset-hold reports `status_o` = 1 with `osc_en_o` = 1 and `clk_en_o` = 0, and any settling is abandoned. When the pin returns high, the block goes to run with no settling count, and `rst_seq_o` is high for one cycle.
- R8: A low hardware-standby pin in standby, settling or reset-hold moves the block to hardware standby. There `status_o` = 3, `hw_stby_o` = 1 and every clock enable is 0. Only the block reset leaves this state.
- R9: When pins act in the same cycle, hardware standby wins over the reset pin, and the reset pin wins over an interrupt edge.
- R10: A write through `edge_sel_we_i` loads `edge_sel_i` into the edge-select bit. 0 selects the falling edge and 1 selects the rising edge.
- R11: In run, the reset and hardware-standby pins do not change the state. An active interrupt edge in run gives a one-cycle `nmi_req_o` and nothing else.
- R12: Each pin edge is recognised once: a single transition yields at most one `nmi_req_o` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator clock |
| rst_i | input | 1 | Synchronous active-high block reset |
| sleep_req_i | input | 1 | One-cycle sleep request from the CPU |
| stby_en_i | input | 1 | Standby-enable bit |
| cks_i | input | 3 | Settling prescaler select code |
| edge_sel_we_i | input | 1 | Write strobe for the edge-select bit |
| edge_sel_i | input | 1 | Edge-select write data (0 falling, 1 rising) |
| nmi_pin_i | input | 1 | Asynchronous interrupt pin |
| rst_pin_n_i | input | 1 | Asynchronous reset pin, active low |
| hwstby_pin_n_i | input | 1 | Asynchronous hardware-standby pin, active low |
| osc_en_o | output | 1 | Oscillator enable |
| clk_en_o | output | 1 | Chip-wide clock enable |
| cnt_clk_en_o | output | 1 | Clock enable for the settling counter only |
| hw_stby_o | output | 1 | Hardware standby entered |
| nmi_req_o | output | 1 | One-cycle request to start interrupt handling |
| rst_seq_o | output | 1 | One-cycle request to start the reset sequence |
| status_o | output | 2 | 0 run, 1 standby or reset-hold, 2 settling, 3 hardware standby |

## Verification
Every cycle, the assertions check several properties. Settling ends in run only after exactly 256 prescaled ticks, measured against the code captured on entry. Settling keeps the chip clock off while the counter clock is on. Every standby entry follows a permitted sleep request. Hardware standby never leaves on its own. Each return to run carries the matching start pulse for its wake source. Only the bench scenarios can show the rest: which edge polarity counts and which is ignored, that edges during settling are dropped, the same-cycle pin priorities, the reset value of the edge-select bit, and that reset and hardware-standby pins are inert in run.

// File: rtl/sbw_pkg.sv
package sbw_pkg;

    localparam int CKS_W        = 3;
    localparam int DIV_LOG2_MAX = 12;

    typedef enum logic [2:0] {
        ST_RUN      = 3'd0,
        ST_SW_STBY  = 3'd1,
        ST_SETTLE   = 3'd2,
        ST_RST_HOLD = 3'd3,
        ST_HW_STBY  = 3'd4
    } sbw_state_e;

    typedef enum logic [1:0] {
        STAT_RUN    = 2'd0,
        STAT_STBY   = 2'd1,
        STAT_SETTLE = 2'd2,
        STAT_HW     = 2'd3
    } sbw_stat_e;

    typedef struct packed {
        logic nmi;
        logic rst_n;
        logic hwstby_n;
    } sbw_pins_t;

    typedef struct packed {
        logic osc_en;
        logic clk_en;
        logic cnt_clk_en;
        logic hw_stby;
    } sbw_clk_t;

    // log2 of the prescaler ratio for each select code
    function automatic int div_log2(logic [CKS_W-1:0] code);
        case (code)
            3'd0:    return 1;
            3'd1:    return 3;
            3'd2:    return 5;
            3'd3:    return 6;
            3'd4:    return 7;
            3'd5:    return 8;
            3'd6:    return 10;
            default: return 12;
        endcase
    endfunction

    function automatic sbw_stat_e stat_of(sbw_state_e s);
        case (s)
            ST_RUN:    return STAT_RUN;
            ST_SETTLE: return STAT_SETTLE;
            ST_HW_STBY: return STAT_HW;
            default:   return STAT_STBY;
        endcase
    endfunction

    function automatic sbw_clk_t clk_of(sbw_state_e s);
        sbw_clk_t c;
        c.osc_en     = (s == ST_RUN) || (s == ST_SETTLE) || (s == ST_RST_HOLD);
        c.clk_en     = (s == ST_RUN);
        c.cnt_clk_en = (s == ST_SETTLE);
        c.hw_stby    = (s == ST_HW_STBY);
        return c;
    endfunction

endpackage

// File: rtl/sbw_sync.sv
module sbw_sync #(
    parameter int              W       = 3,
    parameter int              STAGES  = 2,
    parameter logic [W-1:0]    RST_VAL = '1
) (
    input  logic         clk_i,
    input  logic         rst_i,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [STAGES-1:0][W-1:0] stg_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            stg_q <= {STAGES{RST_VAL}};
        end else begin
            stg_q <= {stg_q[STAGES-2:0], d_i};
        end
    end

    assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/sbw_edge.sv
module sbw_edge (
    input  logic clk_i,
    input  logic rst_i,
    input  logic level_i,
    input  logic sel_we_i,
    input  logic sel_d_i,
    output logic edge_o
);
    logic prev_q;
    logic sel_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            prev_q <= 1'b1;
            sel_q  <= 1'b0;
        end else begin
            prev_q <= level_i;
            if (sel_we_i) begin
                sel_q <= sel_d_i;
            end
        end
    end

    assign edge_o = sel_q ? (level_i & ~prev_q) : (~level_i & prev_q);
endmodule

// File: rtl/sbw_settle.sv
module sbw_settle import sbw_pkg::*; #(
    parameter int CNT_W = 8
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             start_i,
    input  logic             run_i,
    input  logic [CKS_W-1:0] cks_i,
    output logic             done_o
);
    localparam int PRE_W = DIV_LOG2_MAX;

    logic [PRE_W-1:0] pre_q;
    logic [PRE_W-1:0] lim_q;
    logic [CNT_W-1:0] cnt_q;
    logic             tick;

    assign tick   = run_i && (pre_q == lim_q);
    assign done_o = tick && (&cnt_q);

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            pre_q <= '0;
            lim_q <= '0;
            cnt_q <= '0;
        end else if (start_i) begin
            pre_q <= '0;
            cnt_q <= '0;
            lim_q <= PRE_W'((32'd1 << div_log2(cks_i)) - 32'd1);
        end else if (run_i) begin
            pre_q <= tick ? '0 : pre_q + 1'b1;
            if (tick) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/sbw_fsm.sv
module sbw_fsm import sbw_pkg::*; (
    input  logic       clk_i,
    input  logic       rst_i,
    input  logic       sleep_i,
    input  logic       stby_en_i,
    input  logic       rst_n_i,
    input  logic       hwstby_n_i,
    input  logic       nmi_edge_i,
    input  logic       done_i,
    output sbw_state_e state_o,
    output logic       start_o,
    output logic       nmi_req_o,
    output logic       rst_seq_o
);
    sbw_state_e state_q, state_d;
    logic       nmi_p, rst_p;
    logic       nmi_q, rst_q;

    always_comb begin
        state_d = state_q;
        start_o = 1'b0;
        nmi_p   = 1'b0;
        rst_p   = 1'b0;
        unique case (state_q)
            ST_RUN: begin
                if (nmi_edge_i) nmi_p = 1'b1;
                if (sleep_i && stby_en_i) state_d = ST_SW_STBY;
            end
            ST_SW_STBY: begin
                if (!hwstby_n_i)      state_d = ST_HW_STBY;
                else if (!rst_n_i)    state_d = ST_RST_HOLD;
                else if (nmi_edge_i) begin
                    state_d = ST_SETTLE;
                    start_o = 1'b1;
                end
            end
            ST_SETTLE: begin
                if (!hwstby_n_i)      state_d = ST_HW_STBY;
                else if (!rst_n_i)    state_d = ST_RST_HOLD;
                else if (done_i) begin
                    state_d = ST_RUN;
                    nmi_p   = 1'b1;
                end
            end
            ST_RST_HOLD: begin
                if (!hwstby_n_i)      state_d = ST_HW_STBY;
                else if (rst_n_i) begin
                    state_d = ST_RUN;
                    rst_p   = 1'b1;
                end
            end
            ST_HW_STBY: state_d = ST_HW_STBY;
            default:    state_d = ST_RUN;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            state_q <= ST_RUN;
            nmi_q   <= 1'b0;
            rst_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            nmi_q   <= nmi_p;
            rst_q   <= rst_p;
        end
    end

    assign state_o   = state_q;
    assign nmi_req_o = nmi_q;
    assign rst_seq_o = rst_q;
endmodule

// File: rtl/standby_wake_ctrl.sv
module standby_wake_ctrl import sbw_pkg::*; #(
    parameter int CNT_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             sleep_req_i,
    input  logic             stby_en_i,
    input  logic [CKS_W-1:0] cks_i,
    input  logic             edge_sel_we_i,
    input  logic             edge_sel_i,
    input  logic             nmi_pin_i,
    input  logic             rst_pin_n_i,
    input  logic             hwstby_pin_n_i,
    output logic             osc_en_o,
    output logic             clk_en_o,
    output logic             cnt_clk_en_o,
    output logic             hw_stby_o,
    output logic             nmi_req_o,
    output logic             rst_seq_o,
    output logic [1:0]       status_o
);
    localparam int PIN_W = $bits(sbw_pins_t);

    sbw_pins_t  pin_raw, pin_s;
    sbw_state_e state;
    sbw_clk_t   clks;
    logic       nmi_edge, start, done;

    assign pin_raw = '{nmi: nmi_pin_i, rst_n: rst_pin_n_i, hwstby_n: hwstby_pin_n_i};

    sbw_sync #(.W(PIN_W), .STAGES(SYNC_STAGES), .RST_VAL('1)) u_sync (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .d_i   (pin_raw),
        .q_o   (pin_s)
    );

    sbw_edge u_edge (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .level_i  (pin_s.nmi),
        .sel_we_i (edge_sel_we_i),
        .sel_d_i  (edge_sel_i),
        .edge_o   (nmi_edge)
    );

    sbw_settle #(.CNT_W(CNT_W)) u_settle (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .start_i (start),
        .run_i   (clks.cnt_clk_en),
        .cks_i   (cks_i),
        .done_o  (done)
    );

    sbw_fsm u_fsm (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .sleep_i    (sleep_req_i),
        .stby_en_i  (stby_en_i),
        .rst_n_i    (pin_s.rst_n),
        .hwstby_n_i (pin_s.hwstby_n),
        .nmi_edge_i (nmi_edge),
        .done_i     (done),
        .state_o    (state),
        .start_o    (start),
        .nmi_req_o  (nmi_req_o),
        .rst_seq_o  (rst_seq_o)
    );

    assign clks         = clk_of(state);
    assign osc_en_o     = clks.osc_en;
    assign clk_en_o     = clks.clk_en;
    assign cnt_clk_en_o = clks.cnt_clk_en;
    assign hw_stby_o    = clks.hw_stby;
    assign status_o     = stat_of(state);
endmodule

// File: rtl/sbw_chk.sv
module sbw_chk import sbw_pkg::*; #(
    parameter int CNT_W = 8
) (
    input logic             clk_i,
    input logic             rst_i,
    input logic             sleep_req_i,
    input logic             stby_en_i,
    input logic [CKS_W-1:0] cks_i,
    input logic             osc_en_o,
    input logic             clk_en_o,
    input logic             cnt_clk_en_o,
    input logic             hw_stby_o,
    input logic             nmi_req_o,
    input logic             rst_seq_o,
    input logic [1:0]       status_o
);
    localparam int LW = CNT_W + DIV_LOG2_MAX + 2;

    logic [LW-1:0] len_q;
    logic [LW-1:0] lim_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            len_q <= '0;
            lim_q <= '0;
        end else if (status_o == STAT_SETTLE) begin
            len_q <= len_q + 1'b1;
        end else begin
            len_q <= '0;
            lim_q <= LW'(1) << (CNT_W + div_log2(cks_i));
        end
    end

    // R4
    settle_len_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (status_o == STAT_RUN && $past(status_o) == STAT_SETTLE) |-> (len_q == lim_q));

    // R4
    settle_bound_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (status_o == STAT_SETTLE) |-> (len_q < lim_q));

    // R3
    settle_gate_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (status_o == STAT_SETTLE) |-> (osc_en_o && cnt_clk_en_o && !clk_en_o));

    // R5
    nmi_wake_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (status_o == STAT_RUN && $past(status_o) == STAT_SETTLE) |-> nmi_req_o);

    // R2
    stby_entry_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (status_o == STAT_STBY && $past(status_o) == STAT_RUN) |-> $past(sleep_req_i && stby_en_i));

    // R7
    rst_seq_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        rst_seq_o |-> (clk_en_o && $past(status_o) == STAT_STBY));

    // R8
    hw_sticky_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (status_o == STAT_HW) |=> (status_o == STAT_HW && hw_stby_o && !osc_en_o));
endmodule

bind standby_wake_ctrl sbw_chk #(.CNT_W(CNT_W)) u_chk (
    .clk_i        (clk_i),
    .rst_i        (rst_i),
    .sleep_req_i  (sleep_req_i),
    .stby_en_i    (stby_en_i),
    .cks_i        (cks_i),
    .osc_en_o     (osc_en_o),
    .clk_en_o     (clk_en_o),
    .cnt_clk_en_o (cnt_clk_en_o),
    .hw_stby_o    (hw_stby_o),
    .nmi_req_o    (nmi_req_o),
    .rst_seq_o    (rst_seq_o),
    .status_o     (status_o)
);

// File: tb/standby_wake_ctrl_test.sv
module standby_wake_ctrl_test;
    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic       rst = 1'b1;
    logic       sleep = 1'b0, ssby = 1'b0, eg_we = 1'b0, eg_d = 1'b0;
    logic [2:0] cks = 3'd0;
    logic       nmi_pin = 1'b1, rpin_n = 1'b1, hpin_n = 1'b1;
    logic       osc, clk_en, cnt_en, hw, nreq, rseq;
    logic [1:0] status;

    standby_wake_ctrl uut (
        .clk_i(clk), .rst_i(rst), .sleep_req_i(sleep), .stby_en_i(ssby), .cks_i(cks),
        .edge_sel_we_i(eg_we), .edge_sel_i(eg_d), .nmi_pin_i(nmi_pin),
        .rst_pin_n_i(rpin_n), .hwstby_pin_n_i(hpin_n),
        .osc_en_o(osc), .clk_en_o(clk_en), .cnt_clk_en_o(cnt_en), .hw_stby_o(hw),
        .nmi_req_o(nreq), .rst_seq_o(rseq), .status_o(status)
    );

    int checks = 0, fails = 0;
    int ratio [8] = '{2, 8, 32, 64, 128, 256, 1024, 4096};

    task automatic check(bit ok, string tag, string what, longint act, longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // behavioural reference: 0 run, 1 standby, 2 settling, 3 reset-hold, 4 hw standby
    int ms, n1, n2, n3, r1, r2, h1, h2, eg, mcyc, mlim, mnmi, mrst;
    always @(posedge clk) begin : model
        int ed, nx;
        if (rst) begin
            ms = 0; n1 = 1; n2 = 1; n3 = 1; r1 = 1; r2 = 1; h1 = 1; h2 = 1;
            eg = 0; mcyc = 0; mlim = 0; mnmi = 0; mrst = 0;
        end else begin
            ed = (eg == 1) ? int'(n2 == 1 && n3 == 0) : int'(n2 == 0 && n3 == 1);
            nx = ms; mnmi = 0; mrst = 0;
            case (ms)
                0: begin
                    if (ed != 0) mnmi = 1;
                    if (sleep && ssby) nx = 1;
                end
                1: if (h2 == 0) nx = 4;
                   else if (r2 == 0) nx = 3;
                   else if (ed != 0) begin nx = 2; mcyc = 0; mlim = 256 * ratio[cks]; end
                2: if (h2 == 0) nx = 4;
                   else if (r2 == 0) nx = 3;
                   else if (mcyc == mlim - 1) begin nx = 0; mnmi = 1; end
                   else mcyc++;
                3: if (h2 == 0) nx = 4;
                   else if (r2 == 1) begin nx = 0; mrst = 1; end
                default: nx = ms;
            endcase
            ms = nx;
            if (eg_we) eg = int'(eg_d);
            n3 = n2; n2 = n1; n1 = int'(nmi_pin);
            r2 = r1; r1 = int'(rpin_n);
            h2 = h1; h1 = int'(hpin_n);
        end
    end

    // per-cycle compare and monitors, sampled 2 ns after the edge
    int settle_cycles = 0, nmi_pulses = 0, rst_pulses = 0;
    always @(posedge clk) begin
        int est;
        #2;
        if (!rst) begin
            est = (ms == 0) ? 0 : (ms == 2) ? 2 : (ms == 4) ? 3 : 1;
            check(status == 2'(est), "R3", "model status", status, est);
            check(clk_en == (ms == 0) && osc == (ms == 0 || ms == 2 || ms == 3) && cnt_en == (ms == 2),
                  "R4", "model clock enables", {clk_en, osc, cnt_en},
                  {ms == 0, ms == 0 || ms == 2 || ms == 3, ms == 2});
            check(nreq == (mnmi == 1), "R5", "model nmi_req", nreq, mnmi);
            check(rseq == (mrst == 1), "R7", "model rst_seq", rseq, mrst);
            check(hw == (ms == 4), "R8", "model hw_stby", hw, ms == 4);
            if (status == 2'd2) settle_cycles++;
            if (nreq) nmi_pulses++;
            if (rseq) rst_pulses++;
        end
    end

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_sleep();
        sleep = 1'b1; tick(1); sleep = 1'b0; tick(1);
    endtask

    task automatic wait_run(int max);
        for (int i = 0; i < max; i++) begin
            if (status == 2'd0) break;
            tick(1);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
        finish_run();
    end

    initial begin
        int p0, r0;
        tick(3); rst = 1'b0; tick(1);
        // R1 reset state
        check(status == 2'd0 && clk_en && osc && !hw && !cnt_en, "R1", "reset state",
              {status, clk_en, osc}, {2'd0, 1'b1, 1'b1});

        // R2 sleep without enable is ignored
        do_sleep(); tick(2);
        check(status == 2'd0 && clk_en, "R2", "sleep with enable low", status, 0);

        // R11 / R12 falling edge in run: one request, stays in run
        p0 = nmi_pulses; nmi_pin = 1'b0; tick(6);
        check(nmi_pulses == p0 + 1, "R12", "pulses per edge in run", nmi_pulses - p0, 1);
        check(status == 2'd0, "R11", "edge in run keeps run", status, 0);

        // R2 enter standby
        ssby = 1'b1; do_sleep();
        check(status == 2'd1 && !clk_en && !osc && !cnt_en, "R2", "standby entry",
              {status, clk_en, osc}, {2'd1, 1'b0, 1'b0});

        // R3 rising edge ignored with falling selected
        nmi_pin = 1'b1; tick(6);
        check(status == 2'd1, "R3", "wrong polarity ignored", status, 1);

        // R3 / R4 / R5 falling edge, code 0
        settle_cycles = 0; p0 = nmi_pulses; cks = 3'd0;
        nmi_pin = 1'b0; tick(4);
        check(status == 2'd2 && osc && cnt_en && !clk_en, "R3", "settling gates",
              {status, osc, cnt_en, clk_en}, {2'd2, 1'b1, 1'b1, 1'b0});
        wait_run(2000); tick(1);
        check(settle_cycles == 512, "R4", "settle length code 0", settle_cycles, 512);
        check(nmi_pulses == p0 + 1 && clk_en, "R5", "wake request", nmi_pulses - p0, 1);

        // R6 edges during settling ignored, code 1
        do_sleep(); nmi_pin = 1'b1; tick(6);
        settle_cycles = 0; p0 = nmi_pulses; cks = 3'd1;
        nmi_pin = 1'b0; tick(100);
        nmi_pin = 1'b1; tick(10); nmi_pin = 1'b0; tick(10); nmi_pin = 1'b1;
        wait_run(4000); tick(1);
        check(settle_cycles == 2048, "R6", "settle length with noise", settle_cycles, 2048);
        check(nmi_pulses == p0 + 1, "R6", "single request", nmi_pulses - p0, 1);

        // R10 select rising edge, code 3
        eg_d = 1'b1; eg_we = 1'b1; tick(1); eg_we = 1'b0;
        do_sleep(); nmi_pin = 1'b0; tick(6);
        check(status == 2'd1, "R10", "falling ignored when rising selected", status, 1);
        settle_cycles = 0; cks = 3'd3; nmi_pin = 1'b1;
        wait_run(20000); tick(1);
        check(settle_cycles == 16384, "R10", "rising wake, code 3 length", settle_cycles, 16384);

        // R7 reset-pin wake from standby
        do_sleep(); settle_cycles = 0; r0 = rst_pulses;
        rpin_n = 1'b0; tick(4);
        check(status == 2'd1 && osc && !clk_en, "R7", "reset hold", {status, osc, clk_en}, {2'd1, 1'b1, 1'b0});
        rpin_n = 1'b1; tick(4);
        check(status == 2'd0 && rst_pulses == r0 + 1 && settle_cycles == 0, "R7", "reset wake",
              rst_pulses - r0, 1);

        // R7 reset pin aborts settling
        do_sleep(); nmi_pin = 1'b0; tick(5); nmi_pin = 1'b1; tick(5);
        check(status == 2'd2, "R7", "settling before abort", status, 2);
        p0 = nmi_pulses; r0 = rst_pulses; tick(50);
        rpin_n = 1'b0; tick(4);
        check(status == 2'd1 && osc, "R7", "settling abandoned", status, 1);
        rpin_n = 1'b1; tick(4);
        check(status == 2'd0 && rst_pulses == r0 + 1 && nmi_pulses == p0, "R7", "abort wake pulses",
              nmi_pulses - p0, 0);

        // R9 reset pin beats interrupt edge
        do_sleep(); nmi_pin = 1'b0; tick(5);
        nmi_pin = 1'b1; rpin_n = 1'b0; tick(4);
        check(status == 2'd1, "R9", "reset over edge", status, 1);
        rpin_n = 1'b1; tick(4);

        // R9 / R8 hardware standby beats reset pin and is sticky
        do_sleep(); rpin_n = 1'b0; hpin_n = 1'b0; tick(4);
        check(status == 2'd3 && hw && !osc && !clk_en, "R9", "hw over reset", status, 3);
        tick(20); rpin_n = 1'b1; hpin_n = 1'b1; tick(6);
        check(status == 2'd3 && hw, "R8", "hw standby sticky", status, 3);

        // R1 block reset restores falling-edge selection
        rst = 1'b1; tick(2); rst = 1'b0; tick(1);
        check(status == 2'd0 && clk_en, "R1", "run after block reset", status, 0);
        cks = 3'd0; do_sleep(); nmi_pin = 1'b0; tick(4);
        check(status == 2'd2, "R1", "falling edge active after reset", status, 2);
        wait_run(2000); tick(2);

        // R11 reset and hw pins inert in run
        rpin_n = 1'b0; tick(5);
        check(status == 2'd0 && clk_en, "R11", "reset pin in run", status, 0);
        hpin_n = 1'b0; tick(5);
        check(status == 2'd0 && !hw, "R11", "hw pin in run", status, 0);
        rpin_n = 1'b1; hpin_n = 1'b1; tick(5);

        finish_run();
    end
endmodule